// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line. The line is sampled with an enable pulse that arrives at sixteen times the bit rate. When the line goes low, the block checks near the middle of that bit that the start bit is real. It then samples each following bit near its centre and assembles a character of seven or eight bits, least significant bit first. It can also check an even or odd parity bit and the stop bit.

A finished character moves from the internal shift register into a holding register that the host reads. The next character can shift in while the previous one waits to be read. The buffer-full flag, the overrun, parity and framing error flags, and a one-cycle receive interrupt all change in one cycle, when the first stop bit is sampled. The second stop bit of a two-stop format only delays the return to idle. The host clears the buffer-full flag and the error flags by pulsing the read strobe. It can clear only the error flags with a separate pulse.

Top module: `uart_rx_dbuf`

## Requirements
- R1: A frame is one low start bit, then 7 (`cfg_len8`=0) or 8 (`cfg_len8`=1) data bits least significant first, then a parity bit when `cfg_par_en`=1, then one (`cfg_stop2`=0) or two (`cfg_stop2`=1) high stop bits. In 7-bit mode `rx_data[7]` reads 0.
- R2: A low level counts as a start bit only if the line is still low on the eighth oversampling tick, counting the tick that first saw it low. Otherwise the block returns to idle and stores nothing.
- R3: `rbf` goes to 1 when a character enters the buffer and returns to 0 the cycle after a `rd_stb` pulse.
- R4: `pe`, `fe` and `oe` take their new values in the same cycle that the character completes. That cycle falls at the first stop bit, including in two-stop mode.
- R5: `rx_irq` is a one-cycle pulse in the cycle where `rbf` rises, and at no other time.
- R6: If a character completes while `rbf` is 1 and no read happens in that cycle, `oe` becomes 1. The new character is discarded, `rx_data` keeps the old one and no interrupt is raised.
- R7: `fe` becomes 1 when the first stop bit is sampled low. The character is still stored.
- R8: With `cfg_par_en`=1, `pe` becomes 1 when the data bits plus the parity bit hold an odd count of ones (`cfg_par_odd`=0) or an even count (`cfg_par_odd`=1).
- R9: A `clr_err` pulse clears `oe`, `pe` and `fe` and leaves `rbf` and `rx_data` unchanged.
- R10: A second character may arrive while the first is unread. If the host reads before that character completes, it is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | Two stop bits |
| rd_stb | input | 1 | Host read of the buffer |
| clr_err | input | 1 | Clear error flags |
| rx_data | output | 8 | Receive buffer contents |
| rbf | output | 1 | Receive buffer full |
| oe | output | 1 | Overrun error |
| pe | output | 1 | Parity error |
| fe | output | 1 | Framing error |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
On every cycle, the assertions check the following. The interrupt pulse lines up with the rise of the buffer-full flag. An error flag rises only in the cycle after a completed character. A read or a clear pulse empties what it should. During an overrun the stored character does not change. Some behaviour only the bench scenarios can show: correct data assembly for each length and parity combination, where the sampling point sits within a bit, and how a short glitch is rejected. They also show that a read during the second character prevents the overrun, and that the flags are already set while the second stop bit is still on the line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          len_full,
    input  logic          par_en,
    input  logic          stop2,
    output logic          done,
    output logic [DW-1:0] char_out,
    output logic          par_acc,
    output logic          stop_bad
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [DW-1:0] sh;
        logic          par;
        logic          done;
        logic          ferr;
    } frame_t;

    frame_t q, d;
    logic [BW-1:0] last_bit;

    always_comb begin
        last_bit = len_full ? BW'(DW - 1) : BW'(DW - 2);
        d        = q;
        d.done   = 1'b0;
        if (tick) begin
            case (q.state)
                RX_IDLE: begin
                    if (!rx) begin
                        d.state = RX_START;
                        d.cnt   = CW'(1);
                    end
                end
                RX_START: begin
                    if (q.cnt == MID) begin
                        d.cnt  = '0;
                        d.bitn = '0;
                        d.par  = 1'b0;
                        d.state = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {rx, q.sh[DW-1:1]};
                        d.par = q.par ^ rx;
                        if (q.bitn == last_bit) begin
                            d.bitn  = '0;
                            d.state = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.par   = q.par ^ rx;
                        d.state = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.done  = 1'b1;
                        d.ferr  = ~rx;
                        d.state = stop2 ? RX_STOP2 : RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.state = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: RX_IDLE, cnt: '0, bitn: '0, sh: '0,
                   par: 1'b0, done: 1'b0, ferr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign char_out = len_full ? q.sh : (q.sh >> 1);
    assign par_acc  = q.par;
    assign stop_bad = q.ferr;

    // R1: completion is a single-cycle pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R2: an aborted start check never reaches the data phase
    a_r2_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_START && tick && q.cnt == MID && rx) |=> q.state == RX_IDLE);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] char_in,
    input  logic          par_acc,
    input  logic          stop_bad,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] data,
    output logic          rbf,
    output logic          oe,
    output logic          pe,
    output logic          fe,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          rbf;
        logic          oe;
        logic          pe;
        logic          fe;
        logic          irq;
    } buf_t;

    buf_t q, d;
    logic still_full;

    always_comb begin
        still_full = q.rbf & ~rd;
        d          = q;
        d.irq      = 1'b0;
        if (rd) begin
            d.rbf = 1'b0;
            d.oe  = 1'b0;
            d.pe  = 1'b0;
            d.fe  = 1'b0;
        end
        if (clr) begin
            d.oe = 1'b0;
            d.pe = 1'b0;
            d.fe = 1'b0;
        end
        if (done) begin
            d.oe = still_full;
            d.pe = par_en & (par_acc ^ par_odd);
            d.fe = stop_bad;
            if (!still_full) begin
                d.data = char_in;
                d.rbf  = 1'b1;
                d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data = q.data;
    assign rbf  = q.rbf;
    assign oe   = q.oe;
    assign pe   = q.pe;
    assign fe   = q.fe;
    assign irq  = q.irq;

    a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rbf) |-> q.irq);

    a_r5_irq_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> (q.rbf && !$past(q.rbf)));

    a_r4_flags_follow_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.pe) || $rose(q.fe) || $rose(q.oe)) |-> $past(done));

    a_r6_overrun_keeps_char: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.rbf && !rd) |=> (q.oe && q.rbf && $stable(q.data) && !q.irq));

    a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !q.rbf);

    a_r9_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> (!q.oe && !q.pe && !q.fe && $stable(q.data)));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          rd_stb,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          rbf,
    output logic          oe,
    output logic          pe,
    output logic          fe,
    output logic          rx_irq
);
    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] sync_q, sync_d;
    logic              done;
    logic [DW-1:0]     char_w;
    logic              par_w;
    logic              ferr_w;

    always_comb begin
        sync_d = {sync_q[SYNC_N-2:0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    uart_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx       (sync_q[SYNC_N-1]),
        .len_full (cfg_len8),
        .par_en   (cfg_par_en),
        .stop2    (cfg_stop2),
        .done     (done),
        .char_out (char_w),
        .par_acc  (par_w),
        .stop_bad (ferr_w)
    );

    uart_rx_buffer #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .char_in  (char_w),
        .par_acc  (par_w),
        .stop_bad (ferr_w),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .rd       (rd_stb),
        .clr      (clr_err),
        .data     (rx_data),
        .rbf      (rbf),
        .oe       (oe),
        .pe       (pe),
        .fe       (fe),
        .irq      (rx_irq)
    );
endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT        = 16 * TICK_DIV;
    localparam int NVEC       = 8;

    // {len8, par_en, par_odd, stop2, bad_par, bad_stop, sent, exp_data, exp_pe, exp_fe}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h81, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 8'h55, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h0F, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A, 8'h2A, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       rd_stb = 1'b0, clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       rbf, oe, pe, fe, rx_irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    uart_rx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_stb(rd_stb), .clr_err(clr_err),
        .rx_data(rx_data), .rbf(rbf), .oe(oe), .pe(pe), .fe(fe), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            tick16 = (c == TICK_DIV - 1);
            c = (c == TICK_DIV - 1) ? 0 : c + 1;
        end
    end

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v, input int cycles);
        rxd = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_frame(input logic len8, input logic pen, input logic podd,
                              input logic stop2, input logic badpar, input logic badstop,
                              input logic [7:0] dat);
        logic p;
        p = podd ^ badpar;
        hold_bit(1'b0, BIT);
        for (int i = 0; i < (len8 ? 8 : 7); i++) begin
            p = p ^ dat[i];
            hold_bit(dat[i], BIT);
        end
        if (pen) hold_bit(p, BIT);
        if (badstop) begin
            hold_bit(1'b0, BIT / 2 + 16);
            hold_bit(1'b1, BIT / 2 - 16);
        end else begin
            hold_bit(1'b1, BIT);
        end
        if (stop2) hold_bit(1'b1, BIT);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic l8, input logic pen, input logic podd, input logic s2);
        cfg_len8 = l8; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int irq_before;
        repeat (5) @(negedge clk);
        // reset state (R3, R4, R5)
        chk("R3 reset rbf", rbf, 0);
        chk("R4 reset flags", {oe, pe, fe}, 0);
        chk("R5 reset irq", rx_irq, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 idle rbf", rbf, 0);
        chk("R1 reset data", rx_data, 0);

        // table of formats: R1, R7, R8, R3, R5
        for (int k = 0; k < NVEC; k++) begin
            logic [23:0] v;
            v = VEC[k];
            set_cfg(v[23], v[22], v[21], v[20]);
            irq_before = irq_cnt;
            send_frame(v[23], v[22], v[21], v[20], v[19], v[18], v[17:10]);
            repeat (BIT) @(negedge clk);
            chk("R3 rbf after frame", rbf, 1);
            chk("R1 received data", rx_data, v[9:2]);
            chk("R8 parity flag", pe, v[1]);
            chk("R7 framing flag", fe, v[0]);
            chk("R6 no overrun", oe, 0);
            chk("R5 one irq pulse", irq_cnt - irq_before, 1);
            pulse_rd();
            chk("R3 read clears rbf", rbf, 0);
            chk("R3 read clears flags", {oe, pe, fe}, 0);
        end

        // R2: short glitch rejected, then a valid frame still received
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        hold_bit(1'b0, 3 * TICK_DIV);
        hold_bit(1'b1, 12 * BIT);
        chk("R2 glitch stores nothing", rbf, 0);
        send_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
        repeat (BIT) @(negedge clk);
        chk("R2 frame after glitch", rx_data, 8'hC3);
        pulse_rd();

        // R4: flags set while second stop bit still on line
        set_cfg(1'b1, 1'b1, 1'b0, 1'b1);
        fork
            send_frame(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A);
            begin
                repeat (11 * BIT - 4) @(negedge clk);
                chk("R4 rbf before second stop ends", rbf, 1);
                chk("R4 pe at first stop", pe, 1);
            end
        join
        repeat (BIT) @(negedge clk);
        pulse_rd();

        // R10: read during second character avoids overrun
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
        fork
            send_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22);
            begin
                repeat (3 * BIT) @(negedge clk);
                chk("R10 first char held", rx_data, 8'h11);
                pulse_rd();
            end
        join
        repeat (BIT) @(negedge clk);
        chk("R10 second char stored", rx_data, 8'h22);
        chk("R10 no overrun", oe, 0);
        chk("R10 rbf", rbf, 1);

        // R6: overrun while unread
        irq_before = irq_cnt;
        send_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h33);
        repeat (BIT) @(negedge clk);
        chk("R6 overrun flag", oe, 1);
        chk("R6 old char kept", rx_data, 8'h22);
        chk("R6 rbf stays", rbf, 1);
        chk("R6 no irq on overrun", irq_cnt - irq_before, 0);

        // R9: clear pulse affects only error flags
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        @(negedge clk);
        chk("R9 oe cleared", oe, 0);
        chk("R9 rbf kept", rbf, 1);
        chk("R9 data kept", rx_data, 8'h22);
        pulse_rd();
        chk("R3 final read", rbf, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule